// File: doc/BRIEF.md
# Page-Write Sequencer for a Non-Volatile Byte Store

This block accepts byte writes from a bus and collects them in a page buffer. When the write-control input is low, a byte write in the idle state opens a page. The upper address bits of that first write choose a 32-byte aligned page. Each write lands at the offset given by the low five address bits. Every accepted write restarts a load-window timer. When the window runs out with no new write, the block enters a programming phase of fixed length. At the end of that phase it copies the buffered bytes into an internal storage array and pulses an interrupt.

While the write-control input is high, writes are refused. Raising it during the load window throws the pending page away. During programming, reads return a status byte whose bit 6 inverts on each read, so software can poll for completion. Reset clears the loading state but does not stop a programming cycle that is already running. Both timing windows are parameters counted in clock cycles.

The controller has three states: `ST_IDLE`, `ST_LOAD` and `ST_PROG`. Its transitions are:
- open: `ST_IDLE`→`ST_LOAD` on an accepted write.
- extend: `ST_LOAD`→`ST_LOAD` on an accepted write.
- abort: `ST_LOAD`→`ST_IDLE` when write-control is high or reset is asserted.
- close: `ST_LOAD`→`ST_PROG` when the window expires.
- finish: `ST_PROG`→`ST_IDLE` when programming time has elapsed.

Top module: `pgwr_ctrl`

## Requirements
- R1: In the idle state, a write (`wr_en`=1, `wctl`=0, `rst_n`=1 at a rising edge) opens a page. The page is `addr[7:5]` of that write, and the byte goes to offset `addr[4:0]`. Later writes to the same page use only their `addr[4:0]`, so an address outside the page lands at the same offset inside the page of the first write.
- R2: A page holds up to 32 bytes, one per offset. When an offset is written more than once, the last value is the one programmed.
- R3: A write that arrives at most `WIN_CYC` rising edges after the previous accepted write joins the same page. If `WIN_CYC` edges pass with no write, programming starts on that edge, and `busy` is 1 from the following cycle.
- R4: A write made while `wctl`=1 is ignored. If `wctl`=1 is sampled while a page is loading, the page is discarded: no programming happens and the array does not change.
- R5: `busy` stays high for exactly `PROG_CYC` cycles. Writes made while `busy` is high are ignored.
- R6: At the end of programming, only the offsets written in the page change in the array. All other bytes keep their values.
- R7: A read while `busy` is high returns a status byte one cycle later. In that byte bit 6 is the toggle and all other bits are 0. The toggle is 0 for the first read of each programming cycle and inverts on every later read.
- R8: A read while not programming returns the array byte at `addr` one cycle after the request. `rdata` keeps its value between reads.
- R9: `irq` is high for exactly one cycle: the first cycle after `busy` falls.
- R10: Reset is synchronous and active low. It returns the block to idle, discards a loading page and clears `rdata` and `irq`. While programming, reset has no effect: `busy`, the commit and `irq` go ahead unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Byte write request, one cycle per byte |
| rd_en | input | 1 | Byte read request |
| addr | input | ADDR_W | Byte address |
| wdata | input | 8 | Write data |
| wctl | input | 1 | Write control: 0 permits writes, 1 refuses them or aborts a loading page |
| rdata | output | 8 | Read data or polling status |
| busy | output | 1 | High while a programming cycle runs |
| irq | output | 1 | One-cycle pulse when programming completes |

## Verification
The hardest cases sit on the exact edge of the load window. The bench delays a second write to the `WIN_CYC`-th edge and checks that it still joins the page. It then delays a write by one edge more and checks that the write is ignored because programming has already begun. Reset during programming is reached by first closing a page and only then pulling `rst_n` low for a few cycles. The bench then checks that the programming length, the interrupt and the stored byte are all unaffected. The toggle status bit is reached by issuing back-to-back reads in the cycles right after `busy` rises.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
    localparam int BYTE_W = 8;
    localparam int STAT_BIT = 6;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_PROG = 2'd2
    } pg_state_e;
endpackage

// File: rtl/pgwr_timer.sv
module pgwr_timer #(
    parameter int MAX_CYC = 8
) (
    input  logic clk,
    input  logic load,
    input  logic run,
    output logic last
);
    localparam int CW = $clog2(MAX_CYC + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (load) begin
            cnt <= CW'(MAX_CYC);
        end else if (run && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign last = (cnt == CW'(1));
endmodule

// File: rtl/pgwr_pagebuf.sv
module pgwr_pagebuf
    import pgwr_pkg::*;
#(
    parameter int PAGE  = 32,
    parameter int OFF_W = $clog2(PAGE)
) (
    input  logic                         clk,
    input  logic                         clr,
    input  logic                         we,
    input  logic [OFF_W-1:0]             off,
    input  logic [BYTE_W-1:0]            din,
    output logic [PAGE-1:0][BYTE_W-1:0]  pdata,
    output logic [PAGE-1:0]              pvalid
);
    for (genvar j = 0; j < PAGE; j++) begin : g_slot
        always_ff @(posedge clk) begin
            if (we && off == OFF_W'(j)) begin
                pdata[j]  <= din;
                pvalid[j] <= 1'b1;
            end else if (clr) begin
                pvalid[j] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pgwr_store.sv
module pgwr_store
    import pgwr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int PAGE   = 32,
    parameter int OFF_W  = $clog2(PAGE)
) (
    input  logic                         clk,
    input  logic                         commit,
    input  logic [ADDR_W-OFF_W-1:0]      base,
    input  logic [PAGE-1:0][BYTE_W-1:0]  pdata,
    input  logic [PAGE-1:0]              pvalid,
    input  logic [ADDR_W-1:0]            raddr,
    output logic [BYTE_W-1:0]            rbyte
);
    localparam int NBYTES = 1 << ADDR_W;

    logic [BYTE_W-1:0] mem [NBYTES];

    always_ff @(posedge clk) begin
        for (int j = 0; j < PAGE; j++) begin
            if (commit && pvalid[j]) begin
                mem[{base, OFF_W'(j)}] <= pdata[j];
            end
        end
    end

    assign rbyte = mem[raddr];
endmodule

// File: rtl/pgwr_ctrl.sv
module pgwr_ctrl
    import pgwr_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int PAGE     = 32,
    parameter int WIN_CYC  = 8,
    parameter int PROG_CYC = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              wctl,
    output logic [7:0]        rdata,
    output logic              busy,
    output logic              irq
);
    localparam int OFF_W  = $clog2(PAGE);
    localparam int BASE_W = ADDR_W - OFF_W;

    pg_state_e state, nxt;

    logic                         wr_go;
    logic                         accept;
    logic                         open_pg;
    logic                         win_last;
    logic                         prog_last;
    logic                         prog_start;
    logic                         commit;
    logic                         tog;
    logic [BASE_W-1:0]            base_q;
    logic [PAGE-1:0][BYTE_W-1:0]  pdata;
    logic [PAGE-1:0]              pvalid;
    logic [BYTE_W-1:0]            rbyte;

    assign wr_go   = wr_en && !wctl && rst_n;
    assign accept  = wr_go && (state == ST_IDLE || state == ST_LOAD);
    assign open_pg = wr_go && (state == ST_IDLE);

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (wr_go) nxt = ST_LOAD;             // open
            end
            ST_LOAD: begin
                if (!rst_n || wctl) nxt = ST_IDLE;    // abort
                else if (wr_en)     nxt = ST_LOAD;    // extend
                else if (win_last)  nxt = ST_PROG;    // close
            end
            ST_PROG: begin
                if (prog_last) nxt = ST_IDLE;         // finish
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        state <= nxt;
    end

    assign prog_start = (state == ST_LOAD) && (nxt == ST_PROG);
    assign commit     = (state == ST_PROG) && prog_last;
    assign busy       = (state == ST_PROG);

    pgwr_timer #(.MAX_CYC(WIN_CYC)) u_win (
        .clk  (clk),
        .load (accept),
        .run  (state == ST_LOAD),
        .last (win_last)
    );

    pgwr_timer #(.MAX_CYC(PROG_CYC)) u_prog (
        .clk  (clk),
        .load (prog_start),
        .run  (state == ST_PROG),
        .last (prog_last)
    );

    pgwr_pagebuf #(.PAGE(PAGE), .OFF_W(OFF_W)) u_buf (
        .clk    (clk),
        .clr    (open_pg),
        .we     (accept),
        .off    (addr[OFF_W-1:0]),
        .din    (wdata),
        .pdata  (pdata),
        .pvalid (pvalid)
    );

    pgwr_store #(.ADDR_W(ADDR_W), .PAGE(PAGE), .OFF_W(OFF_W)) u_mem (
        .clk    (clk),
        .commit (commit),
        .base   (base_q),
        .pdata  (pdata),
        .pvalid (pvalid),
        .raddr  (addr),
        .rbyte  (rbyte)
    );

    // registered outputs and page base
    always_ff @(posedge clk) begin
        irq <= commit;
        if (open_pg) base_q <= addr[ADDR_W-1:OFF_W];
        if (prog_start) begin
            tog <= 1'b0;
        end else if (rd_en && rst_n && state == ST_PROG) begin
            tog <= ~tog;
        end
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            if (state == ST_PROG) begin
                rdata <= '0;
                rdata[STAT_BIT] <= tog;
            end else begin
                rdata <= rbyte;
            end
        end
    end
endmodule

// File: rtl/pgwr_chk.sv
module pgwr_chk #(
    parameter int PROG_CYC = 20
) (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_en,
    input logic       wctl,
    input logic [7:0] rdata,
    input logic       busy,
    input logic       irq
);
    localparam int RW = $clog2(PROG_CYC + 2);

    logic [RW-1:0] run_len;

    always_ff @(posedge clk) begin
        if (!rst_n) run_len <= '0;
        else if (busy) run_len <= run_len + 1'b1;
        else run_len <= '0;
    end

    always_ff @(posedge clk) begin
        if (rst_n) begin
            assert_prog_len_R5: assert (run_len <= RW'(PROG_CYC))
                else $error("programming exceeded its length");
        end
    end

    assert_irq_on_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> irq);

    assert_irq_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    assert_status_fmt_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_en) |=> (rdata[7] == 1'b0 && rdata[5:0] == 6'd0));

    assert_status_toggle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_en && $past(busy && rd_en && rst_n)) |=> (rdata[6] != $past(rdata[6])));

    assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

    assert_abort_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wctl && !busy) |=> !busy);
endmodule

bind pgwr_ctrl pgwr_chk #(.PROG_CYC(PROG_CYC)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .rd_en (rd_en),
    .wctl  (wctl),
    .rdata (rdata),
    .busy  (busy),
    .irq   (irq)
);

// File: tb/sim_pgwr_ctrl.sv
module sim_pgwr_ctrl;
    localparam int CLK_P = 10;
    localparam int WIN   = 8;
    localparam int PROG  = 20;
    localparam int WAITN = WIN + PROG + 3;

    // {abort flag, first address, byte count, first data}
    localparam logic [31:0] VEC [6] = '{
        {8'd0, 8'h00, 8'd1,  8'h11},
        {8'd0, 8'h20, 8'd32, 8'h40},
        {8'd0, 8'h5C, 8'd8,  8'h80},
        {8'd0, 8'h60, 8'd4,  8'hA0},
        {8'd1, 8'h60, 8'd4,  8'h50},
        {8'd0, 8'hE0, 8'd3,  8'hC5}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       wctl = 1'b0;
    logic [7:0] rdata;
    logic       busy;
    logic       irq;

    int n_cmp = 0;
    int n_bad = 0;

    logic [7:0] mdl [256];
    bit         known [256];

    always #(CLK_P/2) clk = ~clk;

    pgwr_ctrl #(.ADDR_W(8), .PAGE(32), .WIN_CYC(WIN), .PROG_CYC(PROG)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .wctl(wctl), .rdata(rdata), .busy(busy), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic c);
        wr_en = 1'b1; addr = a; wdata = d; wctl = c;
        @(negedge clk);
        wr_en = 1'b0; wctl = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        v = rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_done(output int bc, output int ic);
        bc = 0; ic = 0;
        for (int i = 0; i < WAITN; i++) begin
            @(negedge clk);
            if (busy) bc++;
            if (irq) ic++;
        end
    endtask

    task automatic commit_mdl(input logic [7:0] a, input logic [7:0] d);
        mdl[a] = d;
        known[a] = 1'b1;
    endtask

    task automatic verify(input logic [7:0] a, input string req);
        logic [7:0] v;
        rd(a, v);
        if (known[a]) check(req, v, mdl[a]);
    endtask

    initial begin
        #(CLK_P * 200000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int bc, ic;
        logic [7:0] v;
        for (int i = 0; i < 256; i++) known[i] = 1'b0;

        idle(3);
        // R10: reset state
        check("R10 busy after reset", busy, 0);
        check("R10 irq after reset", irq, 0);
        check("R10 rdata after reset", rdata, 0);
        rst_n = 1'b1;
        idle(1);

        // vector table: R1 R2 R4 R6 R8 R9
        for (int k = 0; k < 6; k++) begin
            logic       ab;
            logic [7:0] a0, nb, sd, pa;
            ab = VEC[k][24];
            a0 = VEC[k][23:16];
            nb = VEC[k][15:8];
            sd = VEC[k][7:0];
            for (int i = 0; i < int'(nb); i++) wr(a0 + 8'(i), sd + 8'(i), 1'b0);
            if (ab) begin
                wctl = 1'b1;
                @(negedge clk);
                wctl = 1'b0;
            end
            wait_done(bc, ic);
            check(ab ? "R4 busy cycles after abort" : "R5 busy cycles", bc, ab ? 0 : PROG);
            check(ab ? "R4 irq after abort" : "R9 irq pulses", ic, ab ? 0 : 1);
            for (int i = 0; i < int'(nb); i++) begin
                pa = {a0[7:5], 5'((a0 + 8'(i)) & 8'h1F)};
                if (!ab) commit_mdl(pa, sd + 8'(i));
            end
            for (int i = 0; i < int'(nb); i++) begin
                pa = {a0[7:5], 5'((a0 + 8'(i)) & 8'h1F)};
                verify(pa, ab ? "R4 array kept after abort" : "R1 R6 R8 readback");
            end
        end

        // R3: write on the WIN-th edge still joins
        wr(8'hC0, 8'h01, 1'b0);
        idle(WIN - 1);
        wr(8'hC1, 8'h02, 1'b0);
        wr(8'hC9, 8'h77, 1'b0);
        wait_done(bc, ic);
        check("R3 one programming cycle for joined writes", bc, PROG);
        commit_mdl(8'hC0, 8'h01);
        commit_mdl(8'hC1, 8'h02);
        commit_mdl(8'hC9, 8'h77);
        verify(8'hC1, "R3 joined byte stored");

        // R3 expiry edge, R5 write while busy ignored
        wr(8'hC8, 8'h03, 1'b0);
        idle(WIN - 1);
        check("R3 not busy before window ends", busy, 0);
        idle(1);
        check("R3 busy after window ends", busy, 1);
        wr(8'hC9, 8'h04, 1'b0);
        wait_done(bc, ic);
        commit_mdl(8'hC8, 8'h03);
        verify(8'hC8, "R6 byte stored");
        verify(8'hC9, "R5 write during programming ignored");

        // R7: toggle status while programming
        wr(8'hA0, 8'h5A, 1'b0);
        idle(WIN);
        rd(8'hA0, v); check("R7 first status", v, 8'h00);
        rd(8'hA0, v); check("R7 second status", v, 8'h40);
        rd(8'hA0, v); check("R7 third status", v, 8'h00);
        idle(PROG + 2);
        commit_mdl(8'hA0, 8'h5A);
        verify(8'hA0, "R8 data after programming");

        // R4: write with wctl high in idle ignored
        wr(8'hC0, 8'hEE, 1'b1);
        wait_done(bc, ic);
        check("R4 no busy after refused write", bc, 0);
        verify(8'hC0, "R4 refused write left array unchanged");

        // R10: reset during loading discards the page
        wr(8'hC1, 8'h99, 1'b0);
        rst_n = 1'b0;
        idle(1);
        rst_n = 1'b1;
        wait_done(bc, ic);
        check("R10 no programming after reset in load", bc, 0);
        verify(8'hC1, "R10 discarded page left array unchanged");

        // R10: reset during programming has no effect
        wr(8'h80, 8'h3C, 1'b0);
        idle(WIN + 1);
        rst_n = 1'b0;
        idle(2);
        check("R10 busy held through reset", busy, 1);
        rst_n = 1'b1;
        wait_done(bc, ic);
        check("R10 irq after reset in programming", ic, 1);
        commit_mdl(8'h80, 8'h3C);
        verify(8'h80, "R10 commit after reset in programming");

        // R1 page crossing, R2 last write wins
        wr(8'h3E, 8'h10, 1'b0);
        wr(8'h41, 8'h20, 1'b0);
        wr(8'h3E, 8'h30, 1'b0);
        wait_done(bc, ic);
        commit_mdl(8'h3E, 8'h30);
        commit_mdl(8'h21, 8'h20);
        verify(8'h3E, "R2 last write wins");
        verify(8'h21, "R1 offset lands in first page");
        verify(8'h41, "R1 other page untouched");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule